// File: doc/BRIEF.md
# Serial Port Register Block (16550-compatible map)

This block places a serial port behind eight byte registers laid out like the classic 16550, so that existing drivers can run it unmodified. A register access carries a byte address and an access width. The register index is taken from the address after a right shift by a configurable amount. Accesses of the wrong width get an error response. Every access is answered one cycle later with a registered response.

Bytes written to the data register leave at once on a valid/ready byte output, so the transmit-empty flags never drop. Bytes arriving on a valid/ready byte input go into a receive queue, which software drains by reading the data register. In loopback mode, written bytes go into the receive queue instead and the external input is shut off. The block combines data-ready, transmit-empty and the interrupt enables into a prioritised identification code and one level interrupt line. The divisor latch is stored but does not drive anything. The modem status reads back as a constant.

Top module: `uart_reg_block`

## Requirements
- R1: The register index is bits [2:0] of `bus_addr >> REG_SHIFT`. Higher address bits are ignored, so with REG_SHIFT=0 the address 0x0F reaches index 7 (scratch), which stores any byte written to it and returns it on read.
- R2: After reset the registers read as follows: enable=0x00, identification=0xC1, line control=0x00, modem control=0x08, line status=0x60, modem status=0xB0, scratch=0x00, divisor low=0x0C and divisor high=0x00.
- R3: While line-control bit 7 is set, index 0 reads and writes the divisor low byte and index 1 the divisor high byte. The data register and the enable register are left untouched.
- R4: A write to the enable register (index 1) stores only its low four bits.
- R5: Index 2 reads 0xC4 when enable bit 0 is set and data is ready. Otherwise it reads 0xC2 when enable bit 1 is set and the transmitter is empty, and 0xC1 when neither holds. `irq` is high exactly when the code is not 0xC1.
- R6: With modem-control bit 4 set (loopback), a data write enters the receive queue only if the queue holds fewer than DEPTH (64) bytes. In this mode nothing appears on `tx_valid` and `rx_ready` stays low.
- R7: Reading the data register returns receive bytes in arrival order. Line-status bit 0 (data ready) clears once the last byte is taken. A read of an empty queue returns 0x00.
- R8: Writing index 2 with bit 1 set empties the receive queue. Writing it with bit 2 set leaves line-status bits 6 and 5 set. Neither bit persists, while bit 0 (receive enable) is kept.
- R9: `rx_ready` is high only while the receive enable (index-2 write bit 0) is set, loopback is off and the queue is not full.
- R10: Writes to line status (index 5) and modem status (index 6) do not change what those registers read.
- R11: An access whose `bus_width` differs from REG_BYTES returns `rsp_error`=1 and changes no register.
- R12: A data write outside loopback and divisor access raises `tx_valid` with the byte on `tx_data` until `tx_ready` is seen. Line status keeps reading 0x60 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_width | input | WIDTH_W | Access width in bytes |
| bus_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_error | output | 1 | Access rejected for its width |
| rsp_rdata | output | 8 | Read data (0 for writes and errors) |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Sink takes the transmit byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Block accepts the receive byte |
| irq | output | 1 | Level interrupt |

## Verification
The register map is driven through a table of reads and writes taken straight out of reset. This covers the reset values, the divisor switching, enable masking and the ignored status writes. A wrong-shift or wrong-mask decode is exposed by an aliased address reaching scratch. Receive traffic is sent first from the external port and then through loopback, each time filling the queue to its limit and draining it. This separates order errors, full-queue handling and data-ready clearing. Interrupt codes are read with the receive and transmit sources enabled separately and together, which shows whether priority encoding is used or the codes are merged.

// File: rtl/urb_pkg.sv
package urb_pkg;

    typedef enum logic [2:0] {
        IDX_DATA    = 3'd0,
        IDX_IEN     = 3'd1,
        IDX_IID     = 3'd2,
        IDX_LCTL    = 3'd3,
        IDX_MCTL    = 3'd4,
        IDX_LSTAT   = 3'd5,
        IDX_MSTAT   = 3'd6,
        IDX_SCRATCH = 3'd7
    } reg_idx_e;

    localparam int LC_DLAB   = 7;
    localparam int MC_LOOP   = 4;
    localparam int FC_RXEN   = 0;
    localparam int FC_RXCLR  = 1;
    localparam int FC_TXCLR  = 2;
    localparam int IE_RXD    = 0;
    localparam int IE_THR    = 1;

    localparam logic [7:0] IID_NONE  = 8'h01;
    localparam logic [7:0] IID_RXD   = 8'h04;
    localparam logic [7:0] IID_THR   = 8'h02;
    localparam logic [7:0] IID_TYPE  = 8'hC0;
    localparam logic [7:0] MSR_FIXED = 8'hB0;
    localparam logic [7:0] MCR_RST   = 8'h08;
    localparam logic [7:0] DLL_RST   = 8'h0C;

    typedef struct packed {
        logic temt;
        logic thre;
        logic dr;
    } line_flags_t;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_idx_e idx;
        logic [7:0] wdata;
    } bus_op_t;

    function automatic logic [7:0] pack_lsr(input line_flags_t f);
        return {1'b0, f.temt, f.thre, 4'b0000, f.dr};
    endfunction

endpackage

// File: rtl/urb_rx_fifo.sv
module urb_rx_fifo #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp_q, rp_q;
    logic [CW-1:0]    count_q;
    logic             do_push, do_pop;

    assign empty   = (count_q == '0);
    assign full    = (count_q == CW'(DEPTH));
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign head    = mem[rp_q];
    assign count   = count_q;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp_q    <= '0;
            rp_q    <= '0;
            count_q <= '0;
        end else begin
            if (do_push) wp_q <= step(wp_q);
            if (do_pop)  rp_q <= step(rp_q);
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // R6
    full_push_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !clr) |=> $stable(count_q));

    // R8
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count_q == '0));

endmodule

// File: rtl/urb_irq_encode.sv
module urb_irq_encode
    import urb_pkg::*;
(
    input  logic [3:0]  ien,
    input  line_flags_t flags,
    output logic [7:0]  iid,
    output logic        pending
);
    logic rxd_hit, thr_hit;

    assign rxd_hit = ien[IE_RXD] && flags.dr;
    assign thr_hit = ien[IE_THR] && flags.temt;

    always_comb begin
        if (rxd_hit)      iid = IID_RXD;
        else if (thr_hit) iid = IID_THR;
        else              iid = IID_NONE;
    end

    assign pending = rxd_hit || thr_hit;

    // R5
    prio_rx_over_tx_chk: assert final (!(rxd_hit && thr_hit) || iid == IID_RXD);

endmodule

// File: rtl/uart_reg_block.sv
module uart_reg_block
    import urb_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int REG_SHIFT = 0,
    parameter int REG_BYTES = 1,
    parameter int WIDTH_W   = 4,
    parameter int DEPTH     = 64,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WIDTH_W-1:0] bus_width,
    input  logic [7:0]         bus_wdata,
    output logic               rsp_valid,
    output logic               rsp_error,
    output logic [7:0]         rsp_rdata,
    output logic               tx_valid,
    output logic [7:0]         tx_data,
    input  logic               tx_ready,
    input  logic               rx_valid,
    input  logic [7:0]         rx_data,
    output logic               rx_ready,
    output logic               irq
);
    localparam logic [WIDTH_W-1:0] WIDTH_OK = WIDTH_W'(REG_BYTES);

    logic [3:0]  ien_q;
    logic [7:0]  lcr_q, mcr_q, scr_q, dll_q, dlm_q;
    logic        rxen_q;
    logic        thr_empty_q;
    logic        txv_q;
    logic [7:0]  txd_q;

    logic [ADDR_W-1:0] shifted;
    bus_op_t     op;
    logic        width_ok, dlab, loop;
    logic        data_wr, data_rd;
    logic        q_clr, q_push, q_pop, q_empty, q_full;
    logic [7:0]  q_head, q_in;
    logic [CW-1:0] q_count;
    line_flags_t flags;
    logic [7:0]  iid;
    logic        pending;
    logic [7:0]  rd_val;

    // ---------------- access decode ----------------
    assign shifted  = bus_addr >> REG_SHIFT;
    assign width_ok = (bus_width == WIDTH_OK);
    assign op.rd    = bus_valid && width_ok && !bus_write;
    assign op.wr    = bus_valid && width_ok && bus_write;
    assign op.idx   = reg_idx_e'(shifted[2:0]);
    assign op.wdata = bus_wdata;

    assign dlab    = lcr_q[LC_DLAB];
    assign loop    = mcr_q[MC_LOOP];
    assign data_wr = op.wr && op.idx == IDX_DATA && !dlab;
    assign data_rd = op.rd && op.idx == IDX_DATA && !dlab;

    // ---------------- receive queue ----------------
    assign rx_ready = rxen_q && !loop && !q_full;
    assign q_clr    = op.wr && op.idx == IDX_IID && op.wdata[FC_RXCLR];
    assign q_push   = loop ? (data_wr && !q_full) : (rx_valid && rx_ready);
    assign q_in     = loop ? op.wdata : rx_data;
    assign q_pop    = data_rd && !q_empty;

    urb_rx_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .clr       (q_clr),
        .push      (q_push),
        .push_data (q_in),
        .pop       (q_pop),
        .head      (q_head),
        .count     (q_count),
        .empty     (q_empty),
        .full      (q_full)
    );

    // ---------------- status and interrupt ----------------
    assign flags.dr   = !q_empty;
    assign flags.thre = thr_empty_q;
    assign flags.temt = thr_empty_q;

    urb_irq_encode u_irq (
        .ien     (ien_q),
        .flags   (flags),
        .iid     (iid),
        .pending (pending)
    );

    assign irq = pending;

    // ---------------- register file ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q       <= '0;
            lcr_q       <= '0;
            mcr_q       <= MCR_RST;
            scr_q       <= '0;
            dll_q       <= DLL_RST;
            dlm_q       <= '0;
            rxen_q      <= 1'b0;
            thr_empty_q <= 1'b1;
        end else if (op.wr) begin
            case (op.idx)
                IDX_DATA: begin
                    if (dlab) dll_q <= op.wdata;
                    else      thr_empty_q <= 1'b1;
                end
                IDX_IEN: begin
                    if (dlab) begin
                        dlm_q <= op.wdata;
                    end else begin
                        ien_q <= op.wdata[3:0];
                        if (!op.wdata[IE_THR]) thr_empty_q <= 1'b1;
                    end
                end
                IDX_IID: begin
                    rxen_q <= op.wdata[FC_RXEN];
                    if (op.wdata[FC_TXCLR]) thr_empty_q <= 1'b1;
                end
                IDX_LCTL:    lcr_q <= op.wdata;
                IDX_MCTL:    mcr_q <= op.wdata;
                IDX_SCRATCH: scr_q <= op.wdata;
                default: ;
            endcase
        end
    end

    // ---------------- transmit hand-off ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            txv_q <= 1'b0;
            txd_q <= '0;
        end else if (data_wr && !loop) begin
            txv_q <= 1'b1;
            txd_q <= op.wdata;
        end else if (txv_q && tx_ready) begin
            txv_q <= 1'b0;
        end
    end

    assign tx_valid = txv_q;
    assign tx_data  = txd_q;

    // ---------------- read mux and response ----------------
    always_comb begin
        case (op.idx)
            IDX_DATA:    rd_val = dlab ? dll_q : (q_empty ? 8'h00 : q_head);
            IDX_IEN:     rd_val = dlab ? dlm_q : {4'b0000, ien_q};
            IDX_IID:     rd_val = iid | IID_TYPE;
            IDX_LCTL:    rd_val = lcr_q;
            IDX_MCTL:    rd_val = mcr_q;
            IDX_LSTAT:   rd_val = pack_lsr(flags);
            IDX_MSTAT:   rd_val = MSR_FIXED;
            default:     rd_val = scr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_error <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= bus_valid;
            rsp_error <= bus_valid && !width_ok;
            rsp_rdata <= op.rd ? rd_val : 8'h00;
        end
    end

    // R11
    bad_width_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !width_ok) |=> (rsp_error && $stable(scr_q) && $stable(lcr_q)
                                      && $stable(ien_q) && $stable(q_count)));

    // R6
    loop_no_tx_chk: assert property (@(posedge clk) disable iff (rst)
        (loop && !txv_q) |=> !txv_q);

    // R9
    loop_rx_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (loop && rx_valid && !bus_valid) |=> $stable(q_count));

    // R5
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (ien_q[IE_RXD] || ien_q[IE_THR]));

    // R12
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (txv_q && !tx_ready && !data_wr) |=> (txv_q && $stable(txd_q)));

endmodule

// File: tb/uart_reg_block_tb.sv
module uart_reg_block_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SHIFT = 0;
    localparam int NV = 28;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_valid = 0, bus_write = 0;
    logic [7:0] bus_addr = 0;
    logic [3:0] bus_width = 4'd1;
    logic [7:0] bus_wdata = 0;
    logic       rsp_valid, rsp_error;
    logic [7:0] rsp_rdata;
    logic       tx_valid, rx_ready, irq;
    logic [7:0] tx_data;
    logic       tx_ready = 0, rx_valid = 0;
    logic [7:0] rx_data = 0;

    int checks = 0, errors = 0;
    logic [7:0] got;
    logic       got_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_reg_block u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_width(bus_width), .bus_wdata(bus_wdata),
        .rsp_valid(rsp_valid), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready), .irq(irq)
    );

    // vector: {req tag number, write, index, wdata, expected read}
    localparam logic [27:0] VEC [NV] = '{
        {8'd2, 1'b0, 3'd1, 8'h00, 8'h00},  // R2 enable
        {8'd2, 1'b0, 3'd2, 8'h00, 8'hC1},  // R2 identification
        {8'd2, 1'b0, 3'd3, 8'h00, 8'h00},  // R2 line control
        {8'd2, 1'b0, 3'd4, 8'h00, 8'h08},  // R2 modem control
        {8'd2, 1'b0, 3'd5, 8'h00, 8'h60},  // R2 line status
        {8'd2, 1'b0, 3'd6, 8'h00, 8'hB0},  // R2 modem status
        {8'd2, 1'b0, 3'd7, 8'h00, 8'h00},  // R2 scratch
        {8'd1, 1'b1, 3'd7, 8'hA5, 8'h00},  // R1 scratch write
        {8'd1, 1'b0, 3'd7, 8'h00, 8'hA5},  // R1 scratch read
        {8'd3, 1'b1, 3'd3, 8'h80, 8'h00},  // R3 divisor access on
        {8'd2, 1'b0, 3'd0, 8'h00, 8'h0C},  // R2 divisor low
        {8'd2, 1'b0, 3'd1, 8'h00, 8'h00},  // R2 divisor high
        {8'd3, 1'b1, 3'd0, 8'h34, 8'h00},  // R3
        {8'd3, 1'b1, 3'd1, 8'h12, 8'h00},  // R3
        {8'd3, 1'b0, 3'd0, 8'h00, 8'h34},  // R3
        {8'd3, 1'b0, 3'd1, 8'h00, 8'h12},  // R3
        {8'd3, 1'b1, 3'd3, 8'h03, 8'h00},  // R3 divisor access off
        {8'd3, 1'b0, 3'd3, 8'h00, 8'h03},  // R3
        {8'd3, 1'b0, 3'd1, 8'h00, 8'h00},  // R3 enable untouched
        {8'd4, 1'b1, 3'd1, 8'hFE, 8'h00},  // R4
        {8'd4, 1'b0, 3'd1, 8'h00, 8'h0E},  // R4 upper bits dropped
        {8'd5, 1'b0, 3'd2, 8'h00, 8'hC2},  // R5 transmit-empty code
        {8'd5, 1'b1, 3'd1, 8'h00, 8'h00},  // R5
        {8'd5, 1'b0, 3'd2, 8'h00, 8'hC1},  // R5
        {8'd10, 1'b1, 3'd5, 8'h00, 8'h00}, // R10
        {8'd10, 1'b0, 3'd5, 8'h00, 8'h60}, // R10
        {8'd10, 1'b1, 3'd6, 8'h00, 8'h00}, // R10
        {8'd10, 1'b0, 3'd6, 8'h00, 8'hB0}  // R10
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // entered and left at a falling edge
    task automatic acc(input logic wr, input logic [7:0] addr, input logic [7:0] wd,
                       input logic [3:0] w);
        bus_valid = 1'b1; bus_write = wr; bus_addr = addr; bus_wdata = wd; bus_width = w;
        @(posedge clk);
        @(negedge clk);
        got = rsp_rdata; got_err = rsp_error;
        bus_valid = 1'b0;
    endtask

    task automatic wr_reg(input int idx, input logic [7:0] d);
        acc(1'b1, 8'(idx << SHIFT), d, 4'd1);
    endtask

    task automatic rd_reg(input int idx);
        acc(1'b0, 8'(idx << SHIFT), 8'h00, 4'd1);
    endtask

    task automatic rx_send(input logic [7:0] d);
        rx_valid = 1'b1; rx_data = d;
        @(posedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R2 irq low", {7'b0, irq}, 8'h00);
        chk("R2 tx idle", {7'b0, tx_valid}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            v = VEC[i];
            acc(v[19], 8'(int'(v[18:16]) << SHIFT), v[15:8], 4'd1);
            if (!v[19]) chk($sformatf("R%0d vector %0d", v[27:20], i), got, v[7:0]);
        end

        // R1 aliasing: upper address bits ignored
        acc(1'b1, 8'h0F << SHIFT, 8'h3C, 4'd1);
        rd_reg(7);
        chk("R1 alias", got, 8'h3C);

        // R11 width mismatch
        acc(1'b1, 8'h07, 8'h99, 4'd2);
        chk("R11 error flag", {7'b0, got_err}, 8'h01);
        rd_reg(7);
        chk("R11 scratch kept", got, 8'h3C);
        chk("R11 good access no error", {7'b0, got_err}, 8'h00);

        // R12 transmit hand-off
        wr_reg(0, 8'h41);
        chk("R12 tx_valid", {7'b0, tx_valid}, 8'h01);
        chk("R12 tx_data", tx_data, 8'h41);
        rd_reg(5);
        chk("R12 status", got, 8'h60);
        chk("R12 still held", {7'b0, tx_valid}, 8'h01);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        chk("R12 taken", {7'b0, tx_valid}, 8'h00);

        // R9 receive enable gating
        chk("R9 disabled", {7'b0, rx_ready}, 8'h00);
        wr_reg(2, 8'h01);
        chk("R9 enabled", {7'b0, rx_ready}, 8'h01);
        rx_send(8'h11); rx_send(8'h22); rx_send(8'h33);
        rd_reg(5);
        chk("R7 data ready", got, 8'h61);

        // R5 priority
        wr_reg(1, 8'h01);
        chk("R5 irq rx", {7'b0, irq}, 8'h01);
        rd_reg(2);
        chk("R5 rx code", got, 8'hC4);
        wr_reg(1, 8'h03);
        rd_reg(2);
        chk("R5 both -> rx", got, 8'hC4);
        wr_reg(1, 8'h02);
        rd_reg(2);
        chk("R5 tx only", got, 8'hC2);
        wr_reg(1, 8'h00);
        chk("R5 irq off", {7'b0, irq}, 8'h00);

        // R7 order and empty handling
        rd_reg(0); chk("R7 first", got, 8'h11);
        rd_reg(0); chk("R7 second", got, 8'h22);
        rd_reg(0); chk("R7 third", got, 8'h33);
        rd_reg(5); chk("R7 ready cleared", got, 8'h60);
        rd_reg(0); chk("R7 empty read", got, 8'h00);

        // R9 full queue
        for (int i = 0; i < 64; i++) rx_send(8'(i + 1));
        chk("R9 full blocks", {7'b0, rx_ready}, 8'h00);

        // R8 clear
        wr_reg(2, 8'h07);
        rd_reg(5);
        chk("R8 cleared status", got, 8'h60);
        chk("R8 enable kept", {7'b0, rx_ready}, 8'h01);
        rx_send(8'h77);
        rd_reg(0);
        chk("R8 queue usable", got, 8'h77);

        // R6 loopback
        wr_reg(4, 8'h18);
        chk("R6 rx shut", {7'b0, rx_ready}, 8'h00);
        rx_send(8'hEE);
        for (int i = 0; i < 65; i++) wr_reg(0, 8'(i + 8'h80));
        chk("R6 nothing sent", {7'b0, tx_valid}, 8'h00);
        rd_reg(5);
        chk("R6 data ready", got, 8'h61);
        begin
            int bad = 0;
            for (int i = 0; i < 64; i++) begin
                rd_reg(0);
                if (got !== 8'(i + 8'h80)) bad++;
            end
            chk("R6 loop order", 8'(bad), 8'h00);
        end
        rd_reg(0);
        chk("R6 65th dropped", got, 8'h00);
        rd_reg(5);
        chk("R7 drained", got, 8'h60);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule